// File: doc/BRIEF.md
# Record/Playback Sampling Sequencer

This block drives the control pins of a parallel-output successive-approximation ADC and an external asynchronous SRAM that share one 8-bit data bus. Together they form a simple audio recorder. The block alternates between two sweeps over the whole RAM address space, record and playback. A sample tick from outside sets the rate at which addresses are visited.

In record, each accepted tick pulses the converter's active-low start strobe. The block then waits for the converter's active-low interrupt. Next it lowers the converter's read strobe so the sample lands on the bus, and pulses the RAM write enable inside that read window. Last, it steps the address. If the interrupt never comes, a timer releases the sequence and raises a one-cycle timeout flag. The address does not move, so the next tick retries the same location.

In playback, the converter is left alone and the RAM output enable stays low, so the DAC follows stored data. Each tick holds the address for a fixed read window and then steps it. When the address wraps from its top value to zero, the mode flips.

All strobe widths and the timeout are parameters counted in clock cycles.

Top module: `rec_play_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are `rec_mode`=1 (record), `ram_addr`=0, `adc_wr_n`, `adc_rd_n` and `ram_we_n` high, and `timeout_o`=0. After `rst_n` rises, ticks on the next two rising clock edges are ignored.
- R2: In record, a `sample_tick` sampled high while the sequencer is idle makes `adc_wr_n` low for exactly `WR_CYC` cycles, starting in the next cycle.
- R3: Once `adc_wr_n` has risen, the first edge that samples `adc_intr_n` low starts a read window. `adc_rd_n` is then low for `RDS_CYC + WE_CYC + 1` cycles.
- R4: `ram_we_n` falls `RDS_CYC` cycles after `adc_rd_n` falls and stays low for `WE_CYC` cycles. It rises one cycle before `adc_rd_n` rises, so it is only ever low while `adc_rd_n` is low.
- R5: In playback (`rec_mode`=0), `adc_wr_n`, `adc_rd_n` and `ram_we_n` stay high and `ram_oe_n` stays low.
- R6: In record, `ram_oe_n` stays high, so `ram_oe_n` and `adc_rd_n` are never low together.
- R7: `ram_addr` steps by exactly 1 on the same edge that `adc_rd_n` rises in record. In playback it steps `RD_CYC` cycles after the tick is accepted. It does not change at any other time.
- R8: A step from address 2^`ADDR_W`-1 goes to 0 and toggles `rec_mode` on the same edge.
- R9: If `adc_intr_n` is not sampled low within `TMO_CYC` cycles after `adc_wr_n` rises, the sequencer returns to idle. In that case `timeout_o` is high for exactly one cycle and `ram_addr` is unchanged.
- R10: A `sample_tick` that arrives while a record or playback access is in progress has no effect on any output.
- R11: When playback reaches an address, the bus carries the sample that the converter delivered when that address was last written in record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_tick | input | 1 | One-cycle request to process the next address |
| adc_intr_n | input | 1 | Converter end-of-conversion, active low |
| adc_wr_n | output | 1 | Converter start strobe, active low, conversion starts on its rise |
| adc_rd_n | output | 1 | Converter read strobe, active low, converter drives the bus while low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_addr | output | ADDR_W | RAM address |
| rec_mode | output | 1 | 1 while recording, 0 while playing back |
| timeout_o | output | 1 | One-cycle pulse when a conversion never signalled completion |

## Verification
The assertions assume that `adc_intr_n` and `sample_tick` are synchronous to `clk`. They also assume that the converter drops its interrupt only after a start strobe and releases it once the read strobe goes low.

The bench drives both inputs on the falling clock edge, and its converter model follows exactly that behaviour. A switch in the model makes the converter ignore a start strobe, which provokes a timeout. Tick rates both slower and faster than one full access are applied, so accepted and ignored ticks both occur. The run covers several mode wraps with a small address width, so that playback data can be compared against what was recorded.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONV  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_SETUP = 3'd3,
    ST_WRITE = 3'd4,
    ST_HOLD  = 3'd5,
    ST_FETCH = 3'd6
  } rps_state_e;

  function automatic int rps_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rps_rst_sync.sv
module rps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= 1'b1;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rps_dwell_timer.sv
module rps_dwell_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/rps_addr_ctr.sv
module rps_addr_ctr #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              rec_mode
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              mode_q, mode_d;
  logic              at_top;

  always_comb begin
    at_top = (addr_q == ADDR_TOP);
    addr_d = at_top ? '0 : addr_q + 1'b1;
    mode_d = at_top ? ~mode_q : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= 1'b1;
    end else if (step) begin
      addr_q <= addr_d;
      mode_q <= mode_d;
    end
  end

  assign addr     = addr_q;
  assign rec_mode = mode_q;

endmodule

// File: rtl/rps_seq_fsm.sv
module rps_seq_fsm
  import rps_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int WR_CYC  = 5,
  parameter int TMO_CYC = 64,
  parameter int RDS_CYC = 2,
  parameter int WE_CYC  = 4,
  parameter int RD_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic             adc_intr_n,
  input  logic             rec_mode,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             addr_step,
  output logic             adc_wr_n,
  output logic             adc_rd_n,
  output logic             ram_we_n,
  output logic             timeout_o
);

  localparam logic [CNT_W-1:0] WR_LD  = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LD = CNT_W'(TMO_CYC - 1);
  localparam logic [CNT_W-1:0] RDS_LD = CNT_W'(RDS_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LD  = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);

  rps_state_e st_q, st_d;
  logic       tmo_q, tmo_d;

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    addr_step = 1'b0;
    tmo_d     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (sample_tick) begin
          tmr_load = 1'b1;
          if (rec_mode) begin
            st_d    = ST_CONV;
            tmr_val = WR_LD;
          end else begin
            st_d    = ST_FETCH;
            tmr_val = RD_LD;
          end
        end
      end
      ST_CONV: begin
        if (tmr_expired) begin
          st_d     = ST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TMO_LD;
        end
      end
      ST_WAIT: begin
        if (!adc_intr_n) begin
          st_d     = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = RDS_LD;
        end else if (tmr_expired) begin
          st_d  = ST_IDLE;
          tmo_d = 1'b1;
        end
      end
      ST_SETUP: begin
        if (tmr_expired) begin
          st_d     = ST_WRITE;
          tmr_load = 1'b1;
          tmr_val  = WE_LD;
        end
      end
      ST_WRITE: begin
        if (tmr_expired) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        st_d      = ST_IDLE;
        addr_step = 1'b1;
      end
      ST_FETCH: begin
        if (tmr_expired) begin
          st_d      = ST_IDLE;
          addr_step = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmo_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmo_q <= tmo_d;
    end
  end

  assign adc_wr_n  = (st_q != ST_CONV);
  assign adc_rd_n  = !((st_q == ST_SETUP) || (st_q == ST_WRITE) || (st_q == ST_HOLD));
  assign ram_we_n  = (st_q != ST_WRITE);
  assign timeout_o = tmo_q;

endmodule

// File: rtl/rec_play_seq.sv
module rec_play_seq
  import rps_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int WR_CYC     = 5,
  parameter int TMO_CYC    = 4096,
  parameter int RDS_CYC    = 2,
  parameter int WE_CYC     = 4,
  parameter int RD_CYC     = 4,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              adc_intr_n,
  output logic              adc_wr_n,
  output logic              adc_rd_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              rec_mode,
  output logic              timeout_o
);

  localparam int MAX_CYC = rps_max(rps_max(rps_max(WR_CYC, TMO_CYC),
                                           rps_max(RDS_CYC, WE_CYC)), RD_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             rst_int_n;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             addr_step;

  rps_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rps_dwell_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  rps_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .step     (addr_step),
    .addr     (ram_addr),
    .rec_mode (rec_mode)
  );

  rps_seq_fsm #(
    .CNT_W   (CNT_W),
    .WR_CYC  (WR_CYC),
    .TMO_CYC (TMO_CYC),
    .RDS_CYC (RDS_CYC),
    .WE_CYC  (WE_CYC),
    .RD_CYC  (RD_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sample_tick (sample_tick),
    .adc_intr_n  (adc_intr_n),
    .rec_mode    (rec_mode),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .addr_step   (addr_step),
    .adc_wr_n    (adc_wr_n),
    .adc_rd_n    (adc_rd_n),
    .ram_we_n    (ram_we_n),
    .timeout_o   (timeout_o)
  );

  assign ram_oe_n = rec_mode;

endmodule

// File: rtl/rec_play_seq_chk.sv
module rec_play_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adc_wr_n,
  input logic              adc_rd_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              rec_mode,
  input logic              timeout_o
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  p_start_only_rec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_wr_n) |-> rec_mode);

  p_we_within_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> !adc_rd_n);

  p_we_rise_rd_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> !adc_rd_n);

  p_play_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_mode |-> (adc_wr_n && adc_rd_n && ram_we_n));

  p_no_bus_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!adc_rd_n && !ram_oe_n));

  p_addr_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ram_addr) |-> (ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));

  p_mode_on_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_addr == '0 && $past(ram_addr) == ADDR_TOP) |-> (rec_mode != $past(rec_mode)));

  p_mode_only_on_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_mode != $past(rec_mode)) |-> (ram_addr == '0));

  p_tmo_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  p_tmo_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> $stable(ram_addr));

endmodule

bind rec_play_seq rec_play_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adc_wr_n  (adc_wr_n),
  .adc_rd_n  (adc_rd_n),
  .ram_we_n  (ram_we_n),
  .ram_oe_n  (ram_oe_n),
  .ram_addr  (ram_addr),
  .rec_mode  (rec_mode),
  .timeout_o (timeout_o)
);

// File: tb/rec_play_seq_tb_top.sv
`timescale 1ns/1ps
module rec_play_seq_tb_top;

  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int WRC   = 5;
  localparam int TMO   = 40;
  localparam int RDS   = 2;
  localparam int WEC   = 3;
  localparam int RDC   = 4;
  localparam int LAT   = 10;

  // model phases
  localparam int P_IDLE = 0, P_CONV = 1, P_WAIT = 2, P_SETUP = 3,
                 P_WRITE = 4, P_HOLD = 5, P_FETCH = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_tick = 1'b0;
  logic          adc_intr_n = 1'b1;
  logic          adc_wr_n, adc_rd_n, ram_we_n, ram_oe_n, rec_mode, timeout_o;
  logic [AW-1:0] ram_addr;

  rec_play_seq #(
    .ADDR_W (AW), .WR_CYC (WRC), .TMO_CYC (TMO),
    .RDS_CYC(RDS), .WE_CYC (WEC), .RD_CYC (RDC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .adc_intr_n(adc_intr_n),
    .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .ram_addr(ram_addr), .rec_mode(rec_mode),
    .timeout_o(timeout_o)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- converter, RAM and bus models ----------------
  logic [7:0] adc_val = 8'h00;
  logic [7:0] next_sample = 8'h11;
  logic [7:0] ram [DEPTH];
  logic       adc_dead = 1'b0;
  logic       wr_prev = 1'b1;
  logic       we_prev = 1'b1;
  int         lat = 0;
  logic [7:0] bus;

  assign bus = !adc_rd_n ? adc_val : (!ram_oe_n ? ram[ram_addr] : 8'h00);

  initial for (int i = 0; i < DEPTH; i++) ram[i] = 8'h00;

  always @(negedge clk) begin
    if (!wr_prev && adc_wr_n && !adc_dead) begin
      lat = LAT;
      adc_val = next_sample;
      next_sample = next_sample + 8'd37;
    end else if (lat > 0) begin
      lat--;
      if (lat == 0) adc_intr_n = 1'b0;
    end
    if (!adc_rd_n) adc_intr_n = 1'b1;
    wr_prev = adc_wr_n;
  end

  always @(negedge clk) begin
    if (!we_prev && ram_we_n) ram[ram_addr] = bus;
    we_prev = ram_we_n;
  end

  // ---------------- tick generator ----------------
  int   tick_per = 0;
  int   tick_cnt = 0;
  logic tick_inj = 1'b0;

  always @(negedge clk) begin
    if (tick_per == 0) begin
      sample_tick = tick_inj;
    end else begin
      tick_cnt++;
      if (tick_cnt >= tick_per) begin
        tick_cnt = 0;
        sample_tick = 1'b1;
      end else begin
        sample_tick = tick_inj;
      end
    end
  end

  // ---------------- behavioural reference model ----------------
  int         m_ph = P_IDLE;
  int         m_cnt = 0;
  int         m_addr = 0;
  logic       m_rec = 1'b1;
  logic       m_tmo = 1'b0;
  logic       m_s1 = 1'b0, m_s2 = 1'b0;
  int         m_wraps = 0;
  int         m_ignored = 0;
  int         m_tmo_cnt = 0;
  logic [7:0] golden [DEPTH];

  initial for (int i = 0; i < DEPTH; i++) golden[i] = 8'h00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = P_IDLE; m_cnt = 0; m_addr = 0; m_rec = 1'b1; m_tmo = 1'b0;
      m_s1 = 1'b0; m_s2 = 1'b0;
    end else begin
      if (m_s2) begin
        bit stp;
        bit tmo;
        stp = 0;
        tmo = 0;
        if (sample_tick && m_ph != P_IDLE) m_ignored++;
        case (m_ph)
          P_IDLE: if (sample_tick) begin
            if (m_rec) begin m_ph = P_CONV;  m_cnt = WRC - 1; end
            else       begin m_ph = P_FETCH; m_cnt = RDC - 1; end
          end
          P_CONV: if (m_cnt == 0) begin m_ph = P_WAIT; m_cnt = TMO - 1; end
                  else m_cnt--;
          P_WAIT: if (!adc_intr_n) begin m_ph = P_SETUP; m_cnt = RDS - 1; end
                  else if (m_cnt == 0) begin m_ph = P_IDLE; tmo = 1; end
                  else m_cnt--;
          P_SETUP: if (m_cnt == 0) begin m_ph = P_WRITE; m_cnt = WEC - 1; end
                   else m_cnt--;
          P_WRITE: if (m_cnt == 0) begin m_ph = P_HOLD; golden[m_addr] = adc_val; end
                   else m_cnt--;
          P_HOLD: begin m_ph = P_IDLE; stp = 1; end
          P_FETCH: if (m_cnt == 0) begin m_ph = P_IDLE; stp = 1; end
                   else m_cnt--;
          default: m_ph = P_IDLE;
        endcase
        if (stp) begin
          if (m_addr == DEPTH - 1) begin m_addr = 0; m_rec = ~m_rec; m_wraps++; end
          else m_addr++;
        end
        m_tmo = tmo;
        if (tmo) m_tmo_cnt++;
      end
      m_s2 = m_s1;
      m_s1 = 1'b1;
    end
  end

  // ---------------- per-cycle comparison ----------------
  int play_checks = 0;
  always @(negedge clk) begin
    string strobe_tag;
    strobe_tag = m_rec ? "R2 start strobe" : "R5 playback start strobe";
    chk(strobe_tag, int'(adc_wr_n), int'(m_ph != P_CONV));
    chk(m_rec ? "R3 read strobe" : "R5 playback read strobe", int'(adc_rd_n),
        int'(!(m_ph == P_SETUP || m_ph == P_WRITE || m_ph == P_HOLD)));
    chk("R4 write enable", int'(ram_we_n), int'(m_ph != P_WRITE));
    chk(m_rec ? "R6 output enable in record" : "R5 output enable in playback",
        int'(ram_oe_n), int'(m_rec));
    chk("R7 address", int'(ram_addr), m_addr);
    chk("R8 mode", int'(rec_mode), int'(m_rec));
    chk("R9 timeout flag", int'(timeout_o), int'(m_tmo));
    if (m_ph == P_FETCH && m_cnt == 0) begin
      play_checks++;
      chk("R11 playback data", int'(bus), int'(golden[m_addr]));
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog R1 actual=%0d expected<=%0d cycles", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int miss_before;
    wait_cyc(4);
    // R1: reset state at the ports
    chk("R1 reset start strobe", int'(adc_wr_n), 1);
    chk("R1 reset read strobe", int'(adc_rd_n), 1);
    chk("R1 reset write enable", int'(ram_we_n), 1);
    chk("R1 reset address", int'(ram_addr), 0);
    chk("R1 reset mode", int'(rec_mode), 1);
    chk("R1 reset timeout", int'(timeout_o), 0);

    // release reset with a tick present during synchronisation (R1: ignored)
    rst_n = 1'b1;
    tick_inj = 1'b1;
    wait_cyc(1);
    tick_inj = 1'b0;
    wait_cyc(3);
    chk("R1 tick during reset release ignored", int'(adc_wr_n), 1);

    // record sweep then playback sweep at a slow tick rate
    tick_per = 40;
    wait_cyc(720);
    chk("R8 two mode wraps seen", int'(m_wraps >= 2), 1);

    // R9: converter never answers once
    wait (m_rec == 1'b1 && m_ph == P_IDLE);
    #1;
    adc_dead = 1'b1;
    wait_cyc(60);
    adc_dead = 1'b0;
    chk("R9 timeout occurred", int'(m_tmo_cnt >= 1), 1);

    // R10: ticks faster than one access
    miss_before = miscompares;
    tick_per = 7;
    wait_cyc(300);
    chk("R10 busy ticks ignored", int'(m_ignored > 0), 1);
    chk("R10 no miscompare with fast ticks", miscompares - miss_before, 0);

    // slow again to complete further sweeps including playback
    tick_per = 40;
    wait_cyc(1000);
    chk("R11 playback samples compared", int'(play_checks >= DEPTH), 1);

    tick_per = 0;
    wait_cyc(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule